// File: doc/BRIEF.md
# Parallel Port Unlock Sequence Detector

This block sits on the adapter side of a host parallel port. It watches the 8-bit data lines and the 4-bit control nibble for a fixed unlock ritual. The ritual opens with the data lines parked at 0xFF while the control nibble steps to 0xC and then back to 0x4. Six fixed data bytes follow. A command byte comes last and is strobed by a control pulse to 0x5 and back to 0x4. When the ritual completes, the block either grants or withdraws access to the adapter's register interface through a single "linked" flag.

Both buses come in through a two-stage synchroniser, and each is compared with its own previous sample. The sequencer only reacts to a change on the data lines or a change on the control nibble, never to a steady level. A sequence that breaks at any point sends the sequencer back to waiting for a new start. A broken sequence never touches the flag. Every command that is recognised produces a one-cycle strobe alongside the flag update.

Top module: `pp_unlock_detect`

## Requirements
- R1: While reset is asserted, and right after it, `linked_o` is 0 and `cmd_stb_o` is 0.
- R2: A full sequence whose command byte is 0xE0 sets `linked_o` to 1.
- R3: A full sequence whose command byte is 0x30 clears `linked_o` to 0.
- R4: A sequence starts only if the data lines read 0xFF when the control nibble changes to 0xC and again when it changes to 0x4. If the data lines read any other value at the 0xC change, the rest of the sequence has no effect.
- R5: After the start, each new data value must match, in order, 0xAA, 0x55, 0x00, 0xFF, 0x87, 0x78. A value that does not match abandons the sequence, and `linked_o` keeps its value.
- R6: A completed sequence whose command byte is neither 0xE0 nor 0x30 gives no strobe and leaves `linked_o` unchanged.
- R7: The command byte is the data value sampled when the control nibble changes to 0x5. It takes effect only when the nibble next changes to 0x4. Any other next control value discards the command.
- R8: Any change of the control nibble while the six fixed bytes are being matched abandons the sequence.
- R9: After an abandoned sequence, the next correct sequence is accepted without a reset.
- R10: Each accepted 0xE0 or 0x30 command produces exactly one `cmd_stb_o` pulse of one clock cycle. The flag changes in the same cycle as that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pp_data_i | input | 8 | Parallel port data lines, asynchronous |
| pp_ctl_i | input | 4 | Parallel port control nibble, asynchronous |
| linked_o | output | 1 | Register interface enabled |
| cmd_stb_o | output | 1 | One-cycle pulse per accepted command |

## Verification
The hardest states to reach from the ports are the abandon paths partway through the ritual. These are a wrong byte at each of the six positions, a stray control edge before each position, and a strobe that ends on the wrong control value. Each of them must leave the flag exactly as it was. The stimulus task builds a whole host-style sequence and can inject a single fault at a chosen position, so the bench sweeps every position. It first puts the flag in the state that a successful command would have changed, so a spurious action would show on `linked_o`. All 256 command byte values are also swept through otherwise correct sequences.

// File: rtl/pp_unlock_pkg.sv
package pp_unlock_pkg;

  localparam int PRE_LEN = 6;
  localparam int IDX_W   = $clog2(PRE_LEN);

  localparam logic [3:0] CTL_REST   = 4'h4;
  localparam logic [3:0] CTL_ARM    = 4'hC;
  localparam logic [3:0] CTL_STROBE = 4'h5;
  localparam logic [7:0] BUS_PARK   = 8'hFF;
  localparam logic [7:0] CMD_OPEN   = 8'hE0;
  localparam logic [7:0] CMD_CLOSE  = 8'h30;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_PRE,
    ST_CMD,
    ST_STB
  } seq_st_e;

  // expected data value for preamble slot idx
  function automatic logic [7:0] pre_byte(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    pre_byte = 8'hAA;
      3'd1:    pre_byte = 8'h55;
      3'd2:    pre_byte = 8'h00;
      3'd3:    pre_byte = 8'hFF;
      3'd4:    pre_byte = 8'h87;
      default: pre_byte = 8'h78;
    endcase
  endfunction

endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int             W      = 8,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   INIT   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] dprev
);

  logic [STAGES:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {(STAGES+1){INIT}};
    else        stg <= {stg[STAGES-1:0], din};
  end

  assign dout  = stg[STAGES-1];
  assign dprev = stg[STAGES];

endmodule

// File: rtl/pp_seq_fsm.sv
module pp_seq_fsm
  import pp_unlock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus,
  input  logic [3:0] ctl,
  input  logic       bus_chg,
  input  logic       ctl_chg,
  output logic       fire_open,
  output logic       fire_close,
  output logic       seq_abort
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PRE_LEN - 1);

  seq_st_e          st, st_n;
  logic [IDX_W-1:0] idx, idx_n;
  logic [7:0]       cmd_q, cmd_n;

  always_comb begin
    st_n       = st;
    idx_n      = idx;
    cmd_n      = cmd_q;
    fire_open  = 1'b0;
    fire_close = 1'b0;
    seq_abort  = 1'b0;
    case (st)
      ST_IDLE: begin
        if (ctl_chg && ctl == CTL_ARM && bus == BUS_PARK) st_n = ST_ARM;
      end
      ST_ARM: begin
        if (ctl_chg) begin
          if (ctl == CTL_REST && bus == BUS_PARK) begin
            st_n  = ST_PRE;
            idx_n = '0;
          end else seq_abort = 1'b1;
        end else if (bus_chg) seq_abort = 1'b1;
      end
      ST_PRE: begin
        if (ctl_chg) seq_abort = 1'b1;
        else if (bus_chg) begin
          if (bus == pre_byte(idx)) begin
            if (idx == IDX_LAST) st_n = ST_CMD;
            else                 idx_n = idx + 1'b1;
          end else seq_abort = 1'b1;
        end
      end
      ST_CMD: begin
        if (ctl_chg) begin
          if (ctl == CTL_STROBE) begin
            cmd_n = bus;
            st_n  = ST_STB;
          end else seq_abort = 1'b1;
        end
      end
      ST_STB: begin
        if (ctl_chg) begin
          if (ctl == CTL_REST) begin
            fire_open  = (cmd_q == CMD_OPEN);
            fire_close = (cmd_q == CMD_CLOSE);
            st_n       = ST_IDLE;
          end else seq_abort = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (seq_abort) st_n = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      idx   <= '0;
      cmd_q <= '0;
    end else begin
      st    <= st_n;
      idx   <= idx_n;
      cmd_q <= cmd_n;
    end
  end

endmodule

// File: rtl/pp_link_out.sv
module pp_link_out (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_open,
  input  logic fire_close,
  output logic linked_o,
  output logic cmd_stb_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      linked_o  <= 1'b0;
      cmd_stb_o <= 1'b0;
    end else begin
      if (fire_open)       linked_o <= 1'b1;
      else if (fire_close) linked_o <= 1'b0;
      cmd_stb_o <= fire_open | fire_close;
    end
  end

endmodule

// File: rtl/pp_unlock_detect.sv
module pp_unlock_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] pp_data_i,
  input  logic [3:0] pp_ctl_i,
  output logic       linked_o,
  output logic       cmd_stb_o
);
  import pp_unlock_pkg::*;

  logic [7:0] bus_s, bus_p;
  logic [3:0] ctl_s, ctl_p;
  logic       bus_chg, ctl_chg;
  logic       fire_open, fire_close, seq_abort;

  pp_sync #(.W(8), .STAGES(SYNC_STAGES), .INIT(BUS_PARK)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .din(pp_data_i), .dout(bus_s), .dprev(bus_p)
  );

  pp_sync #(.W(4), .STAGES(SYNC_STAGES), .INIT(CTL_REST)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .din(pp_ctl_i), .dout(ctl_s), .dprev(ctl_p)
  );

  assign bus_chg = (bus_s != bus_p);
  assign ctl_chg = (ctl_s != ctl_p);

  pp_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .bus(bus_s), .ctl(ctl_s),
    .bus_chg(bus_chg), .ctl_chg(ctl_chg),
    .fire_open(fire_open), .fire_close(fire_close), .seq_abort(seq_abort)
  );

  pp_link_out u_out (
    .clk(clk), .rst_n(rst_n), .fire_open(fire_open), .fire_close(fire_close),
    .linked_o(linked_o), .cmd_stb_o(cmd_stb_o)
  );

endmodule

// File: rtl/pp_unlock_checker.sv
module pp_unlock_checker (
  input logic clk,
  input logic rst_n,
  input logic linked,
  input logic stb,
  input logic fire_open,
  input logic fire_close,
  input logic seq_abort
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!linked && !stb));

  p_open_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire_open |=> (linked && stb));

  p_close_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire_close |=> (!linked && stb));

  p_abort_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |=> (!stb && $stable(linked)));

  p_change_needs_stb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (linked != $past(linked)) |-> stb);

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);

endmodule

bind pp_unlock_detect pp_unlock_checker u_chk (
  .clk(clk), .rst_n(rst_n), .linked(linked_o), .stb(cmd_stb_o),
  .fire_open(fire_open), .fire_close(fire_close), .seq_abort(seq_abort)
);

// File: tb/pp_unlock_detect_test.sv
`timescale 1ns/1ps
module pp_unlock_detect_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus;
  logic [3:0] ctl;
  wire        linked, stb;
  int         checks = 0;
  int         errors = 0;
  int         pulses = 0;
  bit         exp_link = 1'b0;

  always #2.5 clk = ~clk;

  pp_unlock_detect uut (
    .clk(clk), .rst_n(rst_n), .pp_data_i(bus), .pp_ctl_i(ctl),
    .linked_o(linked), .cmd_stb_o(stb)
  );

  always @(negedge clk) if (rst_n && stb) pulses = pulses + 1;

  function automatic logic [7:0] key(input int i);
    logic [7:0] t [6] = '{8'hAA, 8'h55, 8'h00, 8'hFF, 8'h87, 8'h78};
    return t[i];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_bus(input logic [7:0] v);
    @(negedge clk); bus = v; repeat (4) @(posedge clk);
  endtask

  task automatic put_ctl(input logic [3:0] v);
    @(negedge clk); ctl = v; repeat (4) @(posedge clk);
  endtask

  // one host-style sequence with at most one injected fault
  task automatic run(input logic [7:0] cmd, input int bad_pos, input bit bad_start,
                     input int glitch, input bit bad_stb, input string tag);
    int  p0;
    bit  good;
    bit  act;
    p0   = pulses;
    good = !bad_start && bad_pos < 0 && glitch < 0 && !bad_stb;
    act  = good && (cmd == 8'hE0 || cmd == 8'h30);
    put_bus(bad_start ? 8'h00 : 8'hFF);
    put_ctl(4'hC);
    put_ctl(4'h4);
    for (int i = 0; i < 6; i++) begin
      if (glitch == i) begin put_ctl(4'h6); put_ctl(4'h4); end
      put_bus(i == bad_pos ? (key(i) ^ 8'h01) : key(i));
    end
    put_bus(cmd);
    put_ctl(4'h5);
    if (bad_stb) put_ctl(4'h6);
    put_ctl(4'h4);
    put_bus(8'hFF);
    repeat (4) @(posedge clk);
    @(negedge clk);
    if (act) exp_link = (cmd == 8'hE0);
    check((pulses - p0) == int'(act), {"R10 pulses ", tag}, pulses - p0, int'(act));
    check(linked == exp_link, {"linked ", tag}, linked, exp_link);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus = 8'hFF; ctl = 4'h4;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(linked == 1'b0, "R1 reset linked", linked, 0);
    check(stb == 1'b0, "R1 reset strobe", stb, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    check(linked == 1'b0, "R1 after release", linked, 0);

    run(8'hE0, -1, 1'b0, -1, 1'b0, "R2 open");
    run(8'h30, -1, 1'b0, -1, 1'b0, "R3 close");

    // R6 sweep over every command byte (includes R2 and R3 values)
    for (int c = 0; c < 256; c++)
      run(8'(c), -1, 1'b0, -1, 1'b0,
          (c == 'hE0) ? "R2 sweep" : (c == 'h30) ? "R3 sweep" : "R6 sweep");

    // linked is 1 now: faulty close sequences must leave it set
    for (int p = 0; p < 6; p++) run(8'h30, p, 1'b0, -1, 1'b0, "R5 bad byte");
    for (int g = 0; g < 6; g++) run(8'h30, -1, 1'b0, g, 1'b0, "R8 ctl glitch");
    run(8'h30, -1, 1'b0, -1, 1'b1, "R7 bad strobe");
    run(8'h30, -1, 1'b0, -1, 1'b0, "R9 recover close");
    run(8'hE0, -1, 1'b1, -1, 1'b0, "R4 bad start");
    run(8'hE0, -1, 1'b0, -1, 1'b0, "R9 recover open");

    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(linked == 1'b0, "R1 mid-run reset", linked, 0);
    check(stb == 1'b0, "R1 mid-run strobe", stb, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule